// File: doc/BRIEF.md
# Host/Local Command Mailbox with Engine Ownership Arbiter

This block is a small memory-mapped register file shared by two masters: a host reaching it over a system bus and a local processor on its own bus. Both sides see the same byte-addressed map through identical synchronous read/write ports. A 44-byte mailbox, organised as eleven 32-bit words, carries command structures from host to local processor and response structures back. Writing the last mailbox word rings a doorbell toward the other side. The doorbell stays raised until the receiver acknowledges it.

The block also holds an ownership register for a shared crypto engine. Either side may request the engine, keep it as long as it likes, and release it. The `grant_host` / `grant_local` outputs select which side currently drives the engine. A request made while the other side owns the engine waits and is served when the owner releases it.

The mailbox state machine has three states. `MB_OPEN` means no doorbell is raised. `MB_CMD_PEND` means the host has rung toward the local side. `MB_RSP_PEND` means the local side has rung toward the host. The transitions are:
- ring_cmd: OPEN or RSP_PEND to CMD_PEND.
- ring_rsp: OPEN or CMD_PEND to RSP_PEND.
- ack_cmd: CMD_PEND to OPEN.
- ack_rsp: RSP_PEND to OPEN.

The ownership state machine has the states `OWN_FREE`, `OWN_HOST` and `OWN_LOCAL`. Its transitions are:
- take: FREE to HOST or LOCAL.
- release_idle: owner to FREE.
- handover: owner directly to the waiting side.

Top module: `cmd_mailbox_arbiter`

Address map (byte addresses; bits [1:0] are ignored and each access covers a whole word):
- 0x00 to 0x28: mailbox words 0 to 10. Word 10 is at 0x28.
- 0x30: per-side status/acknowledge register.
- 0x34: ownership command register, which is write-only.
- Every other address is unused.

Status register bits, as seen by the reading side:
- bit0: incoming doorbell.
- bit1: outgoing doorbell still pending.
- bit2: sticky write-drop error.
- bits[5:4]: owner code (0 free, 1 host, 2 local).
- bit6: this side's request is waiting.
- bit7: this side holds the grant.
- All other bits read 0.

Ownership command register (0x34) bits:
- bit0: request.
- bit1: release. When bit0 and bit1 are written together, the write counts as a release only.

## Requirements
- R1: After reset no side owns the engine, both doorbells are low, both error bits are clear, every mailbox word reads 0, and both status registers read 0.
- R2: Each side reads the eleven mailbox words at byte offsets 0x00 to 0x28, with address bits [1:0] ignored. Read data appears on the rdata port one clock after rd is asserted. It shows the contents from before any write made in that same cycle.
- R3: A host write to 0x28 in MB_OPEN or MB_RSP_PEND enters MB_CMD_PEND and raises db_to_local. A local write to 0x28 in MB_OPEN or MB_CMD_PEND enters MB_RSP_PEND and raises db_to_host. The two doorbells are never high together.
- R4: The receiver acknowledges its incoming doorbell by writing 1 to status bit0, which returns the state machine to MB_OPEN. The same write from the other side has no effect.
- R5: A mailbox write from the side whose outgoing doorbell is pending is dropped and the mailbox word keeps its value. That side's status bit2 is set and stays set until the side writes 1 to bit2.
- R6: When both sides write the same mailbox word in the same cycle and both are allowed to write, the local data is stored. The host write is dropped and sets the host error bit.
- R7: An ownership request while OWN_FREE grants that side on the next clock. If both sides request in the same cycle, the local side wins and the host request is left waiting.
- R8: A request made while the other side owns the engine sets status bit6 for the requester. The requester is granted on the clock edge that takes the owner's release.
- R9: A release from a side that is not the owner is ignored. A request from the current owner changes nothing. A write with both bit0 and bit1 set acts as a release only.
- R10: Reads from 0x2C, from 0x34, and from any address at 0x38 or above return 0. Writes to those addresses change no state.
- R11: grant_host and grant_local are never high together. They match the owner code in status bits[5:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | ADDR_W | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, one clock after h_rd |
| l_wr | input | 1 | Local write strobe |
| l_rd | input | 1 | Local read strobe |
| l_addr | input | ADDR_W | Local byte address |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data, one clock after l_rd |
| db_to_host | output | 1 | Response doorbell toward the host |
| db_to_local | output | 1 | Command doorbell toward the local processor |
| grant_host | output | 1 | Engine owned by the host |
| grant_local | output | 1 | Engine owned by the local processor |

## Verification
The hardest situations to reach are those where both ports act on the same clock edge. Examples are the two sides writing one mailbox word together, both requesting a free engine, and an owner releasing while the other side's request arrives in that same cycle. Directed sequences set each of these up explicitly from an idle map. A long seeded random phase then drives both ports at once, with addresses biased toward the mailbox, status and ownership words and with small write values, so that these collisions recur from many different states. A cycle-accurate bench model predicts every read and output.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        MB_OPEN     = 2'd0,
        MB_CMD_PEND = 2'd1,
        MB_RSP_PEND = 2'd2
    } mb_state_e;

    typedef enum logic [1:0] {
        OWN_FREE  = 2'd0,
        OWN_HOST  = 2'd1,
        OWN_LOCAL = 2'd2
    } own_state_e;

    localparam int SIDE_HOST  = 0;
    localparam int SIDE_LOCAL = 1;

    // bit positions inside the status and ownership command words
    localparam int ST_DB_IN  = 0;
    localparam int ST_DB_OUT = 1;
    localparam int ST_ERR    = 2;
    localparam int ST_OWN_LO = 4;
    localparam int ST_PEND   = 6;
    localparam int ST_GRANT  = 7;
    localparam int OC_REQ    = 0;
    localparam int OC_REL    = 1;

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
    parameter int ADDR_W   = 8,
    parameter int MB_WORDS = 11,
    parameter int IDX_W    = $clog2(MB_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              mb_sel,
    output logic [IDX_W-1:0]  idx,
    output logic              st_sel,
    output logic              own_sel
);
    localparam int WA_W = ADDR_W - 2;
    localparam logic [WA_W-1:0] MB_END  = WA_W'(MB_WORDS);
    localparam logic [WA_W-1:0] ST_WORD = WA_W'(MB_WORDS + 1);
    localparam logic [WA_W-1:0] OC_WORD = WA_W'(MB_WORDS + 2);

    logic [WA_W-1:0] word;

    always_comb begin
        word    = addr[ADDR_W-1:2];
        mb_sel  = (word < MB_END);
        idx     = word[IDX_W-1:0];
        st_sel  = (word == ST_WORD);
        own_sel = (word == OC_WORD);
    end
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
    parameter int MB_WORDS = 11,
    parameter int IDX_W    = $clog2(MB_WORDS),
    parameter int DATA_W   = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             h_wr,
    input  logic [IDX_W-1:0]                 h_idx,
    input  logic [DATA_W-1:0]                h_data,
    input  logic                             h_ok,
    input  logic                             l_wr,
    input  logic [IDX_W-1:0]                 l_idx,
    input  logic [DATA_W-1:0]                l_data,
    input  logic                             l_ok,
    output logic [MB_WORDS-1:0][DATA_W-1:0]  words,
    output logic                             h_drop,
    output logic                             l_drop,
    output logic                             h_ring,
    output logic                             l_ring
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(MB_WORDS - 1);

    logic h_take, l_take;

    always_comb begin
        l_take = l_wr && l_ok;
        h_take = h_wr && h_ok && !(l_take && (l_idx == h_idx));
        h_drop = h_wr && !h_take;
        l_drop = l_wr && !l_take;
        h_ring = h_take && (h_idx == LAST);
        l_ring = l_take && (l_idx == LAST);
    end

    for (genvar w = 0; w < MB_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[w] <= '0;
            end else if (l_take && (l_idx == IDX_W'(w))) begin
                words[w] <= l_data;
            end else if (h_take && (h_idx == IDX_W'(w))) begin
                words[w] <= h_data;
            end
        end
    end
endmodule

// File: rtl/mbx_door_fsm.sv
module mbx_door_fsm
    import mbx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      h_ring,
    input  logic      l_ring,
    input  logic      h_ack,
    input  logic      l_ack,
    output mb_state_e state,
    output logic      db_to_host,
    output logic      db_to_local
);
    mb_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            MB_OPEN: begin
                if (l_ring)      state_nx = MB_RSP_PEND;
                else if (h_ring) state_nx = MB_CMD_PEND;
            end
            MB_CMD_PEND: begin
                if (l_ring)      state_nx = MB_RSP_PEND;
                else if (l_ack)  state_nx = MB_OPEN;
            end
            MB_RSP_PEND: begin
                if (h_ring)      state_nx = MB_CMD_PEND;
                else if (h_ack)  state_nx = MB_OPEN;
            end
            default:             state_nx = MB_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= MB_OPEN;
        else        state <= state_nx;
    end

    always_comb begin
        db_to_local = (state == MB_CMD_PEND);
        db_to_host  = (state == MB_RSP_PEND);
    end
endmodule

// File: rtl/own_arb_fsm.sv
module own_arb_fsm
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       h_req,
    input  logic       h_rel,
    input  logic       l_req,
    input  logic       l_rel,
    output own_state_e owner,
    output logic       h_pend,
    output logic       l_pend,
    output logic       grant_host,
    output logic       grant_local
);
    own_state_e owner_nx;
    logic       h_pend_nx, l_pend_nx;

    always_comb begin
        owner_nx  = owner;
        h_pend_nx = h_pend;
        l_pend_nx = l_pend;
        unique case (owner)
            OWN_FREE: begin
                if (l_req) begin
                    owner_nx  = OWN_LOCAL;
                    h_pend_nx = h_req;
                end else if (h_req) begin
                    owner_nx  = OWN_HOST;
                end
            end
            OWN_HOST: begin
                if (h_rel) begin
                    if (l_pend || l_req) owner_nx = OWN_LOCAL;
                    else                 owner_nx = OWN_FREE;
                    l_pend_nx = 1'b0;
                end else if (l_req) begin
                    l_pend_nx = 1'b1;
                end
            end
            OWN_LOCAL: begin
                if (l_rel) begin
                    if (h_pend || h_req) owner_nx = OWN_HOST;
                    else                 owner_nx = OWN_FREE;
                    h_pend_nx = 1'b0;
                end else if (h_req) begin
                    h_pend_nx = 1'b1;
                end
            end
            default: begin
                owner_nx  = OWN_FREE;
                h_pend_nx = 1'b0;
                l_pend_nx = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner  <= OWN_FREE;
            h_pend <= 1'b0;
            l_pend <= 1'b0;
        end else begin
            owner  <= owner_nx;
            h_pend <= h_pend_nx;
            l_pend <= l_pend_nx;
        end
    end

    always_comb begin
        grant_host  = (owner == OWN_HOST);
        grant_local = (owner == OWN_LOCAL);
    end
endmodule

// File: rtl/cmd_mailbox_arbiter.sv
module cmd_mailbox_arbiter
    import mbx_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int MB_WORDS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic              l_wr,
    input  logic              l_rd,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              db_to_host,
    output logic              db_to_local,
    output logic              grant_host,
    output logic              grant_local
);
    localparam int IDX_W = $clog2(MB_WORDS);

    // per-side views, index 0 = host, 1 = local
    logic              wr_v   [2];
    logic              rd_v   [2];
    logic [ADDR_W-1:0] addr_v [2];
    logic [DATA_W-1:0] wd_v   [2];
    logic [DATA_W-1:0] rq_v   [2];
    logic              mb_sel [2];
    logic [IDX_W-1:0]  idx_v  [2];
    logic              st_sel [2];
    logic              oc_sel [2];
    logic              mb_wr  [2];
    logic              ack_v  [2];
    logic              req_v  [2];
    logic              rel_v  [2];
    logic              drop_v [2];
    logic              err_v  [2];
    logic              db_in  [2];
    logic              db_out [2];
    logic              pend_v [2];
    logic              gnt_v  [2];

    logic [MB_WORDS-1:0][DATA_W-1:0] words;
    mb_state_e  mb_state;
    own_state_e owner;
    logic       h_pend, l_pend;
    logic       h_ring, l_ring;

    assign wr_v[0]   = h_wr;
    assign wr_v[1]   = l_wr;
    assign rd_v[0]   = h_rd;
    assign rd_v[1]   = l_rd;
    assign addr_v[0] = h_addr;
    assign addr_v[1] = l_addr;
    assign wd_v[0]   = h_wdata;
    assign wd_v[1]   = l_wdata;
    assign h_rdata   = rq_v[0];
    assign l_rdata   = rq_v[1];

    assign db_in[0]  = db_to_host;
    assign db_in[1]  = db_to_local;
    assign db_out[0] = db_to_local;
    assign db_out[1] = db_to_host;
    assign pend_v[0] = h_pend;
    assign pend_v[1] = l_pend;
    assign gnt_v[0]  = grant_host;
    assign gnt_v[1]  = grant_local;

    for (genvar s = 0; s < 2; s++) begin : g_side
        logic              err_q;
        logic [DATA_W-1:0] rdata_q;
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] rd_val;

        mbx_port_decode #(
            .ADDR_W   (ADDR_W),
            .MB_WORDS (MB_WORDS),
            .IDX_W    (IDX_W)
        ) dec_i (
            .addr    (addr_v[s]),
            .mb_sel  (mb_sel[s]),
            .idx     (idx_v[s]),
            .st_sel  (st_sel[s]),
            .own_sel (oc_sel[s])
        );

        assign mb_wr[s] = wr_v[s] && mb_sel[s];
        assign ack_v[s] = wr_v[s] && st_sel[s] && wd_v[s][ST_DB_IN];
        assign rel_v[s] = wr_v[s] && oc_sel[s] && wd_v[s][OC_REL];
        assign req_v[s] = wr_v[s] && oc_sel[s] && wd_v[s][OC_REQ] && !wd_v[s][OC_REL];

        always_ff @(posedge clk) begin
            if (!rst_n)                                      err_q <= 1'b0;
            else if (drop_v[s])                              err_q <= 1'b1;
            else if (wr_v[s] && st_sel[s] && wd_v[s][ST_ERR]) err_q <= 1'b0;
        end
        assign err_v[s] = err_q;

        always_comb begin
            status                  = '0;
            status[ST_DB_IN]        = db_in[s];
            status[ST_DB_OUT]       = db_out[s];
            status[ST_ERR]          = err_q;
            status[ST_OWN_LO +: 2]  = owner;
            status[ST_PEND]         = pend_v[s];
            status[ST_GRANT]        = gnt_v[s];
            rd_val = '0;
            if (mb_sel[s])      rd_val = words[idx_v[s]];
            else if (st_sel[s]) rd_val = status;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)        rdata_q <= '0;
            else if (rd_v[s])  rdata_q <= rd_val;
        end
        assign rq_v[s] = rdata_q;
    end

    // the side whose outgoing doorbell is pending may not write the mailbox
    mbx_store #(
        .MB_WORDS (MB_WORDS),
        .IDX_W    (IDX_W),
        .DATA_W   (DATA_W)
    ) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .h_wr   (mb_wr[0]),
        .h_idx  (idx_v[0]),
        .h_data (wd_v[0]),
        .h_ok   (mb_state != MB_CMD_PEND),
        .l_wr   (mb_wr[1]),
        .l_idx  (idx_v[1]),
        .l_data (wd_v[1]),
        .l_ok   (mb_state != MB_RSP_PEND),
        .words  (words),
        .h_drop (drop_v[0]),
        .l_drop (drop_v[1]),
        .h_ring (h_ring),
        .l_ring (l_ring)
    );

    mbx_door_fsm door_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .h_ring      (h_ring),
        .l_ring      (l_ring),
        .h_ack       (ack_v[0]),
        .l_ack       (ack_v[1]),
        .state       (mb_state),
        .db_to_host  (db_to_host),
        .db_to_local (db_to_local)
    );

    own_arb_fsm own_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .h_req       (req_v[0]),
        .h_rel       (rel_v[0]),
        .l_req       (req_v[1]),
        .l_rel       (rel_v[1]),
        .owner       (owner),
        .h_pend      (h_pend),
        .l_pend      (l_pend),
        .grant_host  (grant_host),
        .grant_local (grant_local)
    );
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
    parameter int ADDR_W   = 8,
    parameter int MB_WORDS = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_wr,
    input logic              h_rd,
    input logic [ADDR_W-1:0] h_addr,
    input logic [31:0]       h_wdata,
    input logic [31:0]       h_rdata,
    input logic              l_wr,
    input logic [ADDR_W-1:0] l_addr,
    input logic [31:0]       l_wdata,
    input logic              db_to_host,
    input logic              db_to_local,
    input logic              grant_host,
    input logic              grant_local
);
    localparam int WA_W = ADDR_W - 2;
    localparam logic [WA_W-1:0] LAST_W = WA_W'(MB_WORDS - 1);
    localparam logic [WA_W-1:0] ST_W   = WA_W'(MB_WORDS + 1);
    localparam logic [WA_W-1:0] OC_W   = WA_W'(MB_WORDS + 2);
    localparam logic [WA_W-1:0] MB_END = WA_W'(MB_WORDS);

    logic [WA_W-1:0] hw, lw;
    logic h_oc, l_oc, h_unused;

    always_comb begin
        hw       = h_addr[ADDR_W-1:2];
        lw       = l_addr[ADDR_W-1:2];
        h_oc     = h_wr && (hw == OC_W);
        l_oc     = l_wr && (lw == OC_W);
        h_unused = (hw >= MB_END) && (hw != ST_W);
    end

    assert_grant_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_host && grant_local));

    assert_door_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(db_to_host && db_to_local));

    assert_free_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_host && !grant_local && l_oc && l_wdata[0] && !l_wdata[1]) |=> grant_local);

    assert_release_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_host && h_oc && h_wdata[1]) |=> !grant_host);

    assert_owner_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_host && !(h_oc && h_wdata[1])) |=> grant_host);

    assert_door_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (db_to_local && !(l_wr && (lw == ST_W) && l_wdata[0]) && !(l_wr && (lw == LAST_W)))
        |=> db_to_local);

    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && h_unused) |=> (h_rdata == 32'd0));
endmodule

bind cmd_mailbox_arbiter mbx_checker #(
    .ADDR_W   (ADDR_W),
    .MB_WORDS (MB_WORDS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .h_wr        (h_wr),
    .h_rd        (h_rd),
    .h_addr      (h_addr),
    .h_wdata     (h_wdata),
    .h_rdata     (h_rdata),
    .l_wr        (l_wr),
    .l_addr      (l_addr),
    .l_wdata     (l_wdata),
    .db_to_host  (db_to_host),
    .db_to_local (db_to_local),
    .grant_host  (grant_host),
    .grant_local (grant_local)
);

// File: tb/cmd_mailbox_arbiter_tb_top.sv
`timescale 1ns/1ps
module cmd_mailbox_arbiter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_wr = 0, h_rd = 0, l_wr = 0, l_rd = 0;
    logic [7:0]  h_addr = '0, l_addr = '0;
    logic [31:0] h_wdata = '0, l_wdata = '0;
    logic [31:0] h_rdata, l_rdata;
    logic        db_to_host, db_to_local, grant_host, grant_local;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    cmd_mailbox_arbiter dut_i (
        .clk(clk), .rst_n(rst_n),
        .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .db_to_host(db_to_host), .db_to_local(db_to_local),
        .grant_host(grant_host), .grant_local(grant_local)
    );

    // reference model state
    logic [31:0] m_mb [11];
    int          m_door;   // 0 open, 1 command pending, 2 response pending
    int          m_own;    // 0 free, 1 host, 2 local
    logic        m_hp, m_lp, m_herr, m_lerr;

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string req, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input int side, input logic [7:0] a);
        int w;
        logic [31:0] v;
        w = int'(a[7:2]);
        v = '0;
        if (w < 11) v = m_mb[w];
        else if (w == 12) begin
            v[0]   = (side == 0) ? (m_door == 2) : (m_door == 1);
            v[1]   = (side == 0) ? (m_door == 1) : (m_door == 2);
            v[2]   = (side == 0) ? m_herr : m_lerr;
            v[5:4] = 2'(m_own);
            v[6]   = (side == 0) ? m_hp : m_lp;
            v[7]   = (side == 0) ? (m_own == 1) : (m_own == 2);
        end
        return v;
    endfunction

    task automatic model_step(input logic hw, input logic [7:0] ha, input logic [31:0] hd,
                              input logic lw, input logic [7:0] la, input logic [31:0] ld);
        int hwd, lwd;
        logic hmb, lmb, hst, lst, hoc, loc, ht, lt, hrq, hrl, lrq, lrl;
        hwd = int'(ha[7:2]);  lwd = int'(la[7:2]);
        hmb = hw && hwd < 11; lmb = lw && lwd < 11;
        hst = hw && hwd == 12; lst = lw && lwd == 12;
        hoc = hw && hwd == 13; loc = lw && lwd == 13;
        lt  = lmb && m_door != 2;
        ht  = hmb && m_door != 1 && !(lt && lwd == hwd);
        if (hmb && !ht) m_herr = 1'b1; else if (hst && hd[2]) m_herr = 1'b0;
        if (lmb && !lt) m_lerr = 1'b1; else if (lst && ld[2]) m_lerr = 1'b0;
        if (ht) m_mb[hwd] = hd;
        if (lt) m_mb[lwd] = ld;
        case (m_door)
            0: if (lt && lwd == 10) m_door = 2; else if (ht && hwd == 10) m_door = 1;
            1: if (lt && lwd == 10) m_door = 2; else if (lst && ld[0]) m_door = 0;
            default: if (ht && hwd == 10) m_door = 1; else if (hst && hd[0]) m_door = 0;
        endcase
        hrl = hoc && hd[1]; hrq = hoc && hd[0] && !hd[1];
        lrl = loc && ld[1]; lrq = loc && ld[0] && !ld[1];
        case (m_own)
            0: if (lrq) begin m_own = 2; m_hp = hrq; end else if (hrq) m_own = 1;
            1: if (hrl) begin m_own = (m_lp || lrq) ? 2 : 0; m_lp = 0; end
               else if (lrq) m_lp = 1;
            default: if (lrl) begin m_own = (m_hp || hrq) ? 1 : 0; m_hp = 0; end
               else if (hrq) m_hp = 1;
        endcase
    endtask

    // one clock: drive at negedge, check outputs and read data at the next negedge
    task automatic step(input logic hw, input logic hr, input logic [7:0] ha, input logic [31:0] hd,
                        input logic lw, input logic lr, input logic [7:0] la, input logic [31:0] ld,
                        input string tag);
        logic [31:0] eh, el;
        eh = model_read(0, ha);
        el = model_read(1, la);
        h_wr = hw; h_rd = hr; h_addr = ha; h_wdata = hd;
        l_wr = lw; l_rd = lr; l_addr = la; l_wdata = ld;
        model_step(hw, ha, hd, lw, la, ld);
        @(posedge clk);
        @(negedge clk);
        h_wr = 0; h_rd = 0; l_wr = 0; l_rd = 0;
        check(32'(grant_host),  32'(m_own == 1),  "R11", "grant_host");
        check(32'(grant_local), 32'(m_own == 2),  "R11", "grant_local");
        check(32'(db_to_local), 32'(m_door == 1), "R3",  "db_to_local");
        check(32'(db_to_host),  32'(m_door == 2), "R3",  "db_to_host");
        if (hr) check(h_rdata, eh, tag, "host rdata");
        if (lr) check(l_rdata, el, tag, "local rdata");
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d, input string tag);
        step(1, 0, a, d, 0, 0, 8'h0, 0, tag);
    endtask
    task automatic lwrite(input logic [7:0] a, input logic [31:0] d, input string tag);
        step(0, 0, 8'h0, 0, 1, 0, a, d, tag);
    endtask
    task automatic both_read(input logic [7:0] ha, input logic [7:0] la, input string tag);
        step(0, 1, ha, 0, 0, 1, la, 0, tag);
    endtask

    function automatic logic [7:0] pick_addr();
        int r;
        r = int'($urandom % 16);
        if (r < 9)       return 8'((($urandom % 11) << 2) | ($urandom % 4));
        else if (r < 12) return 8'h30;
        else if (r < 14) return 8'h34;
        else             return 8'($urandom);
    endfunction

    function automatic logic [31:0] pick_data();
        if ($urandom % 4 == 0) return $urandom;
        return 32'($urandom % 8);
    endfunction

    initial begin
        void'($urandom(32'h5eed_c0de));
        for (int i = 0; i < 11; i++) m_mb[i] = '0;
        m_door = 0; m_own = 0; m_hp = 0; m_lp = 0; m_herr = 0; m_lerr = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(32'({grant_host, grant_local, db_to_host, db_to_local}), 32'd0, "R1", "outputs after reset");
        for (int i = 0; i < 11; i++) both_read(8'(i * 4), 8'(i * 4), "R1");
        both_read(8'h30, 8'h30, "R1");
        check(h_rdata, 32'd0, "R1", "host status literal");

        // R2: host fills words 0..9, local reads back; unaligned address
        for (int i = 0; i < 10; i++) hwrite(8'(i * 4), 32'hA000_0000 + 32'(i), "R2");
        for (int i = 0; i < 10; i++) both_read(8'(i * 4), 8'(i * 4), "R2");
        hwrite(8'h07, 32'h1234_5678, "R2");
        both_read(8'h04, 8'h06, "R2");
        check(l_rdata, 32'h1234_5678, "R2", "unaligned literal");
        // read in the same cycle as a write shows the old value
        step(1, 0, 8'h08, 32'hBEEF, 0, 1, 8'h08, 0, "R2");

        // R3: host rings the command doorbell
        hwrite(8'h28, 32'hC0DE, "R3");
        check(32'(db_to_local), 32'd1, "R3", "command doorbell literal");
        both_read(8'h30, 8'h30, "R3");

        // R5: host write while its doorbell pends is dropped and flagged
        hwrite(8'h0C, 32'hDEAD, "R5");
        both_read(8'h30, 8'h0C, "R5");
        check(h_rdata, 32'h0000_0006, "R5", "host status literal");
        hwrite(8'h30, 32'h4, "R5");
        both_read(8'h30, 8'h30, "R5");

        // R4: host acknowledge does nothing, local acknowledge clears
        hwrite(8'h30, 32'h1, "R4");
        both_read(8'h30, 8'h30, "R4");
        lwrite(8'h30, 32'h1, "R4");
        both_read(8'h30, 8'h30, "R4");

        // R3: command then response overtakes it
        hwrite(8'h28, 32'h1, "R3");
        lwrite(8'h28, 32'h2, "R3");
        lwrite(8'h00, 32'h3, "R5");
        both_read(8'h30, 8'h30, "R5");
        lwrite(8'h30, 32'h4, "R5");
        hwrite(8'h30, 32'h1, "R4");

        // R6: same-word collision
        step(1, 0, 8'h10, 32'h1111, 1, 0, 8'h10, 32'h2222, "R6");
        both_read(8'h10, 8'h30, "R6");
        check(h_rdata, 32'h2222, "R6", "collision literal");
        both_read(8'h30, 8'h30, "R6");
        hwrite(8'h30, 32'h4, "R6");

        // R7: both request together, local wins, host waits
        step(1, 0, 8'h34, 32'h1, 1, 0, 8'h34, 32'h1, "R7");
        check(32'(grant_local), 32'd1, "R7", "simultaneous request literal");
        both_read(8'h30, 8'h30, "R8");
        // R9: non-owner release and owner re-request ignored
        hwrite(8'h34, 32'h2, "R9");
        lwrite(8'h34, 32'h1, "R9");
        both_read(8'h30, 8'h30, "R9");
        // R8: release hands over
        lwrite(8'h34, 32'h2, "R8");
        check(32'(grant_host), 32'd1, "R8", "handover literal");
        lwrite(8'h34, 32'h1, "R8");
        // R9: request+release together is a release
        hwrite(8'h34, 32'h3, "R9");
        both_read(8'h30, 8'h30, "R9");
        lwrite(8'h34, 32'h2, "R9");
        hwrite(8'h34, 32'h1, "R7");
        hwrite(8'h34, 32'h2, "R8");

        // R10: unused addresses
        hwrite(8'h2C, 32'hFFFF_FFFF, "R10");
        lwrite(8'h38, 32'hFFFF_FFFF, "R10");
        both_read(8'h2C, 8'h34, "R10");
        both_read(8'h38, 8'hFC, "R10");
        both_read(8'h28, 8'h30, "R10");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            step(1'($urandom % 2), 1'($urandom % 2), pick_addr(), pick_data(),
                 1'($urandom % 2), 1'($urandom % 2), pick_addr(), pick_data(), "R2");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule